// File: doc/BRIEF.md
# Edge-Driven Reloadable Frequency Divider

This block is a single timer channel configured as a clock divider for a slow external signal. The external input is brought into the fast operation-clock domain through a synchronizer. A configurable edge detector then turns the selected transitions (rising, falling or both) into one-cycle count strobes. Each strobe steps a 16-bit down counter. When a strobe arrives while the counter holds zero, three things happen on the same strobe: the divided output flips, a one-cycle interrupt pulse is raised, and the counter is refilled from a software-writable reload register.

Software writes the reload value, chooses the edge type and the start mode, and then pulses the start strobe. The first qualifying edge after a start only primes the counter. The start-mode bit decides whether that priming edge also flips the output and raises an interrupt. The reload register may be rewritten at any time. A new value is picked up only at the next refill, so the period that is already running keeps its length. The stop strobe freezes the channel and keeps the output level where it was.

The reload write port is a plain strobe that is always accepted. The block carries no stream traffic, so it has no valid/ready pair and no back-pressure.

Top module: `edge_freq_divider`

## Requirements
- R1: After reset the divided output is 0, the interrupt is 0, the channel is idle and the reload register holds 0.
- R2: The external input passes through two synchronizer flops. A level first captured at operation-clock edge k produces its count strobe in the cycle after edge k+1, and that strobe acts at edge k+2. An interrupt never appears without a strobe one cycle earlier.
- R3: Edge select encoding: 2'b00 counts rising transitions, 2'b01 counts falling transitions, 2'b10 and 2'b11 count both.
- R4: The first strobe after a start loads the counter from the reload register without decrementing it. With start mode 0 that edge neither flips the output nor raises an interrupt. With start mode 1 it does both.
- R5: A strobe that finds the counter at 0x0000 flips the output, raises the interrupt and refills the counter. A strobe that finds a nonzero count decrements it by one.
- R6: With reload value D and single-edge selection, successive interrupts are D+1 input periods apart, so the output period is 2·(D+1) input periods. With both edges selected, they are D+1 input half-periods apart.
- R7: A reload write takes effect at the next refill only. The interrupt interval that is running when the write happens keeps the old length.
- R8: A reload value of 0 flips the output on every counted edge.
- R9: A stop pulse halts counting and holds the output level, and no interrupt follows it. A later start primes again as in R4. If stop and start coincide, stop wins. In a start or stop cycle no strobe is acted on.
- R10: The interrupt is high for exactly the cycles in which the output has just flipped. The output never changes in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; arms the channel for a priming edge |
| stop_i | input | 1 | Stop pulse; halts counting, holds output |
| edge_sel_i | input | 2 | Counted transition type (see R3) |
| start_mode_i | input | 1 | 1: priming edge also flips output and interrupts |
| rld_wr_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | 16 | Reload value |
| ext_in_i | input | 1 | Asynchronous external input being divided |
| div_out_o | output | 1 | Divided output level |
| irq_o | output | 1 | One-cycle pulse per output flip |

## Verification
The hardest situation to reach is a reload write that lands inside a running interval. The proof that matters is that the current interval keeps its old length while the next one takes the new value. To get there, the bench watches for an interrupt and writes a new value right after it. It then measures the two following interrupt gaps separately. Random phases add mid-run writes, stop/start pulses that coincide with counted edges, and fast input toggling in both-edge mode. These runs reach the same boundary while a cycle-level reference model is compared on every clock.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;

  function automatic logic edge_hit(input logic cur, input logic prv, input logic [1:0] sel);
    logic hit;
    case (sel)
      EDGE_RISE: hit = cur & ~prv;
      EDGE_FALL: hit = ~cur & prv;
      default:   hit = cur ^ prv;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/div_in_sync.sv
module div_in_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       raw_i,
  input  logic [1:0] sel_i,
  output logic       stb_o
);
  import div_pkg::*;
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= raw_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[SYNC_STAGES-1];

  assign stb_o = edge_hit(chain_q[SYNC_STAGES-1], prev_q, sel_i);
endmodule

// File: rtl/div_reload_reg.sv
module div_reload_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    val_o <= '0;
    else if (wr_i) val_o <= wdata_i;
endmodule

// File: rtl/div_count_ctrl.sv
module div_count_ctrl #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         mode_i,
  input  logic         stb_i,
  input  logic [W-1:0] reload_i,
  output logic         fire_o,
  output logic         run_o,
  output logic         prime_o,
  output logic [W-1:0] cnt_o
);
  logic act;
  assign act    = run_o && stb_i && !start_i && !stop_i;
  assign fire_o = act && (prime_o ? mode_i : (cnt_o == '0));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_o   <= 1'b0;
      prime_o <= 1'b0;
      cnt_o   <= '0;
    end else if (stop_i) begin
      run_o <= 1'b0;
    end else if (start_i) begin
      run_o   <= 1'b1;
      prime_o <= 1'b1;
    end else if (act) begin
      if (prime_o) begin
        prime_o <= 1'b0;
        cnt_o   <= reload_i;
      end else if (cnt_o == '0) begin
        cnt_o <= reload_i;
      end else begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
endmodule

// File: rtl/div_out_stage.sv
module div_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic out_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= fire_i;
      if (fire_i) out_o <= ~out_o;
    end
endmodule

// File: rtl/edge_freq_divider.sv
module edge_freq_divider #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             start_mode_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-1:0] rld_wdata_i,
  input  logic             ext_in_i,
  output logic             div_out_o,
  output logic             irq_o
);
  logic             edge_stb;
  logic             fire;
  logic             run_q;
  logic             prime_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;

  div_in_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(ext_in_i), .sel_i(edge_sel_i), .stb_o(edge_stb));

  div_reload_reg #(.W(CNT_W)) u_rld (
    .clk(clk), .rst_n(rst_n), .wr_i(rld_wr_i), .wdata_i(rld_wdata_i), .val_o(reload_q));

  div_count_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .mode_i(start_mode_i),
    .stb_i(edge_stb), .reload_i(reload_q), .fire_o(fire), .run_o(run_q),
    .prime_o(prime_q), .cnt_o(cnt_q));

  div_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .out_o(div_out_o), .irq_o(irq_o));
endmodule

// File: rtl/edge_freq_divider_chk.sv
module edge_freq_divider_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             edge_stb,
  input logic             run_q,
  input logic             prime_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             div_out_o,
  input logic             irq_o
);
  AST_FLIP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (div_out_o != $past(div_out_o))); // R10
  AST_HOLD_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> $stable(div_out_o)); // R10
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !irq_o); // R9
  AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(edge_stb)); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !prime_q && edge_stb && !start_i && !stop_i && cnt_q != '0)
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R5
endmodule

bind edge_freq_divider edge_freq_divider_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .edge_stb(edge_stb),
  .run_q(run_q), .prime_q(prime_q), .cnt_q(cnt_q), .div_out_o(div_out_o), .irq_o(irq_o));

// File: tb/test_edge_freq_divider.sv
module test_edge_freq_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, start_mode_i = 1'b0, rld_wr_i = 1'b0;
  logic [1:0]  edge_sel_i = 2'b00;
  logic [15:0] rld_wdata_i = '0;
  logic        ext_in_i = 1'b0;
  logic        div_out_o, irq_o;

  int checks = 0, errors = 0, cyc = 0, prints = 0;
  int irq_n = 0;
  int irq_t [0:15];
  bit gen_en = 0, gen_rand = 0;
  int hp = 2, ph = 0;

  always #5 clk = ~clk;

  edge_freq_divider i_edge_freq_divider (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .edge_sel_i(edge_sel_i),
    .start_mode_i(start_mode_i), .rld_wr_i(rld_wr_i), .rld_wdata_i(rld_wdata_i),
    .ext_in_i(ext_in_i), .div_out_o(div_out_o), .irq_o(irq_o));

  // reference model built from the requirements
  logic m_s0 = 0, m_s1 = 0, m_pv = 0, m_run = 0, m_prime = 0, m_out = 0, m_irq = 0;
  logic [15:0] m_cnt = 0, m_rld = 0;

  function automatic logic f_edge(logic cur, logic prv, logic [1:0] sel);
    if (sel == 2'b00) return cur & ~prv;
    if (sel == 2'b01) return ~cur & prv;
    return cur ^ prv;
  endfunction

  function automatic int f_gap(logic [1:0] sel, int d, int h);
    return (sel[1] ? 1 : 2) * (d + 1) * h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= 0; m_s1 <= 0; m_pv <= 0; m_run <= 0; m_prime <= 0;
      m_out <= 0; m_irq <= 0; m_cnt <= 0; m_rld <= 0;
    end else begin
      logic ve, fire;
      ve = f_edge(m_s1, m_pv, edge_sel_i);
      fire = 0;
      m_s0 <= ext_in_i; m_s1 <= m_s0; m_pv <= m_s1;
      if (rld_wr_i) m_rld <= rld_wdata_i;
      if (stop_i) m_run <= 0;
      else if (start_i) begin m_run <= 1; m_prime <= 1; end
      else if (m_run && ve) begin
        if (m_prime) begin m_prime <= 0; m_cnt <= m_rld; fire = start_mode_i; end
        else if (m_cnt == 0) begin m_cnt <= m_rld; fire = 1; end
        else m_cnt <= m_cnt - 1;
      end
      m_irq <= fire;
      if (fire) m_out <= ~m_out;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      if (prints < 20) $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      prints++;
    end
  endtask

  // per-cycle model comparison, input generator, irq log
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(div_out_o === m_out, "R2 R3 R4 R5 model div_out", int'(div_out_o), int'(m_out));
      check(irq_o === m_irq, "R2 R4 R5 R10 model irq", int'(irq_o), int'(m_irq));
      if (irq_o) begin
        if (irq_n < 16) irq_t[irq_n] = cyc;
        irq_n++;
      end
    end
    if (gen_rand) ext_in_i <= $urandom_range(0, 3) == 0 ? ~ext_in_i : ext_in_i;
    else if (gen_en) begin
      if (ph >= hp - 1) begin ext_in_i <= ~ext_in_i; ph = 0; end
      else ph++;
    end
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pulse_start(logic mode);
    @(negedge clk); start_mode_i = mode; start_i = 1;
    @(negedge clk); start_i = 0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
  endtask
  task automatic write_rld(int v);
    @(negedge clk); rld_wr_i = 1; rld_wdata_i = 16'(v);
    @(negedge clk); rld_wr_i = 0;
  endtask
  task automatic wait_irqs(int n);
    int t = 0;
    while (irq_n < n && t < 5000) begin @(negedge clk); t++; end
    #1;
  endtask
  task automatic clr_irqs();
    @(posedge clk); #1; irq_n = 0;
  endtask

  task automatic period_test(logic [1:0] sel, int d, int h, string req);
    pulse_stop();
    edge_sel_i = sel; hp = h; gen_en = 1;
    write_rld(d);
    pulse_start(1'b0);
    clr_irqs();
    wait_irqs(4);
    check(irq_t[3] - irq_t[2] == f_gap(sel, d, h), req, irq_t[3] - irq_t[2], f_gap(sel, d, h));
    check(irq_t[2] - irq_t[1] == f_gap(sel, d, h), req, irq_t[2] - irq_t[1], f_gap(sel, d, h));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(div_out_o === 1'b0, "R1 reset div_out", int'(div_out_o), 0);
    check(irq_o === 1'b0, "R1 reset irq", int'(irq_o), 0);
    rst_n = 1;
    // R1: reload reg is 0 after reset -> D=0 behaviour without any write
    edge_sel_i = 2'b00; hp = 3; gen_en = 1;
    pulse_start(1'b0); clr_irqs(); wait_irqs(3);
    check(irq_t[2] - irq_t[1] == 6, "R1 reset reload 0", irq_t[2] - irq_t[1], 6);

    period_test(2'b00, 3, 2, "R6 rising D=3");
    period_test(2'b01, 2, 3, "R3 R6 falling D=2");
    period_test(2'b10, 4, 2, "R3 R6 both D=4");
    period_test(2'b11, 1, 3, "R3 R6 both-alt D=1");
    period_test(2'b00, 0, 2, "R8 D=0 rising");
    period_test(2'b10, 0, 3, "R8 D=0 both");

    // R7: write right after an irq; running interval keeps old length
    pulse_stop(); edge_sel_i = 2'b00; hp = 2; write_rld(3);
    pulse_start(1'b0); clr_irqs();
    wait_irqs(2);
    write_rld(1);
    wait_irqs(4);
    check(irq_t[2] - irq_t[1] == 16, "R7 old interval kept", irq_t[2] - irq_t[1], 16);
    check(irq_t[3] - irq_t[2] == 8, "R7 new value next", irq_t[3] - irq_t[2], 8);

    // R9: stop holds output, no irq while input keeps running
    begin
      logic held;
      pulse_stop(); held = div_out_o; clr_irqs();
      repeat (80) @(negedge clk);
      #1;
      check(irq_n == 0, "R9 no irq after stop", irq_n, 0);
      check(div_out_o == held, "R9 output held", int'(div_out_o), int'(held));
    end

    // R4: priming edge with mode 1 interrupts early, mode 0 does not
    write_rld(20); hp = 2; edge_sel_i = 2'b00;
    pulse_start(1'b1); clr_irqs();
    repeat (12) @(negedge clk);
    #1;
    check(irq_n == 1, "R4 mode1 priming irq", irq_n, 1);
    pulse_stop(); pulse_start(1'b0); clr_irqs();
    repeat (12) @(negedge clk);
    #1;
    check(irq_n == 0, "R4 mode0 silent priming", irq_n, 0);

    // R9: stop and start together -> stop wins, channel stays quiet
    write_rld(0);
    @(negedge clk); stop_i = 1; start_i = 1;
    @(negedge clk); stop_i = 0; start_i = 0;
    clr_irqs();
    repeat (40) @(negedge clk);
    #1;
    check(irq_n == 0, "R9 stop beats start", irq_n, 0);

    // random phases, compared against the model every cycle
    for (int it = 0; it < 40; it++) begin
      edge_sel_i = 2'($urandom_range(0, 3));
      hp = $urandom_range(1, 4);
      gen_rand = ($urandom_range(0, 3) == 0);
      write_rld($urandom_range(0, 6));
      pulse_start(1'($urandom_range(0, 1)));
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        rld_wr_i = ($urandom_range(0, 40) == 0);
        rld_wdata_i = 16'($urandom_range(0, 6));
        stop_i = ($urandom_range(0, 150) == 0);
        start_i = ($urandom_range(0, 150) == 0);
        start_mode_i = 1'($urandom_range(0, 1));
      end
      @(negedge clk); rld_wr_i = 0; stop_i = 0; start_i = 0;
    end
    gen_rand = 0; gen_en = 0;
    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule